// File: doc/BRIEF.md
# Serial Command Word Controller for a Dual-Channel Sampling Converter

This block takes a 12-bit command word on one serial data pin while a read strobe is held high. It captures the word into a control register and turns the register's fields into the settings a dual-channel sampling converter needs. The settings are the input-pairing code, the channel pair to convert, power-saving requests, the special read mode and one-cycle command strobes for the DAC and for a device reset. Bits are taken on the falling clock edge. A complete word is applied on the first rising edge after its last bit, so settings never change while a word is still arriving.

Two static mode pins are also registered and exported. The sequencing pin selects manual or automatic sequencing. In manual sequencing the channel pair comes from the serial word. In automatic sequencing the serial word is ignored, and an internal pointer flips between pair 0 and pair 1 on every conversion-done pulse. The output-width pin selects two serial outputs or one shared output, and the block exports that choice as a flag.

Top module: `cmd_word_ctrl`

## Requirements
- R1: While `rst` is high at a rising edge, every output is cleared on that edge: `cmd_word` is 0x000, all flags and strobes are 0, and the automatic pointer returns to pair 0.
- R2: While `rd_en` is high, `sdi` is sampled on each falling edge of `clk`, most significant bit first. On the first rising edge after the 12th sampled bit, `cmd_word` shows the word if the word is accepted (see R6 and R9).
- R3: If `rd_en` goes low before 12 bits have been sampled, the partial word is discarded and every output keeps its previous value. The next word starts again from its first bit.
- R4: Field positions are: bits 11:10 the input-pairing code (C), bits 9:8 the action code (P), bit 7 deep power-down, bit 6 nap, bit 5 automatic nap, bit 4 reference off, bit 3 special read, bits 2:0 the command code (A). An accepted word copies C to `chan_cfg`. In manual mode, P=00 sets `pair_sel` to 0 and P=11 sets it to 1.
- R5: Only an accepted word with P=01 loads bits 7..3 into `deep_pd`, `nap_pd`, `auto_nap`, `ref_off` and `special_rd`. Other accepted words leave these five flags unchanged.
- R6: A word with P=10 is ignored completely, including its C field and `cmd_word`.
- R7: For an accepted word with P=01, A=001 pulses `dac_wr_stb` and A=011 pulses `dac_rd_stb`, each high for exactly one cycle. No other A value pulses either strobe.
- R8: An accepted word with P=01 and A=101 pulses `dev_rst_stb` for one cycle and returns all state to the R1 values, including `cmd_word`=0x000 and the automatic pointer.
- R9: While `auto_mode` is 1, complete words are ignored. `pair_sel` follows the automatic pointer, which flips on every rising edge where `conv_done` is high. In manual mode `conv_done` has no effect.
- R10: `auto_mode` follows `m0_auto`, and `dual_sdo` is the inverse of `m1_single`, each one rising edge after the pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial and system clock; bits are sampled on the falling edge, state updates on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| rd_en | input | 1 | Read strobe; high while a command word is shifted in |
| sdi | input | 1 | Serial command data, MSB first |
| m0_auto | input | 1 | Sequencing mode pin: 1 = automatic, 0 = manual |
| m1_single | input | 1 | Output-width pin: 1 = single shared output, 0 = two outputs |
| conv_done | input | 1 | One-cycle pulse at the end of each conversion |
| cmd_word | output | 12 | Last accepted command word |
| chan_cfg | output | 2 | Input-pairing code from the C field |
| pair_sel | output | 1 | Channel pair to convert (0 or 1) |
| deep_pd | output | 1 | Deep power-down request |
| nap_pd | output | 1 | Nap power-down request |
| auto_nap | output | 1 | Automatic nap enable |
| ref_off | output | 1 | Reference turned off |
| special_rd | output | 1 | Special read mode enable |
| dac_wr_stb | output | 1 | One-cycle DAC write strobe |
| dac_rd_stb | output | 1 | One-cycle DAC read strobe |
| dev_rst_stb | output | 1 | One-cycle device reset strobe |
| auto_mode | output | 1 | Registered sequencing mode flag |
| dual_sdo | output | 1 | Registered flag: 1 = both serial outputs in use |

## Verification
Some properties are checked on every cycle. The bit counter stays in range and returns to zero when the strobe drops. The command strobes are single-cycle and mutually exclusive, and a reset command leaves a zeroed word. The register is frozen in automatic mode, the pointer flips on each conversion pulse, and the mode flags track their pins.
Other behaviour needs the bench's scenarios. These cover MSB-first field placement, discarding of truncated words, whether each action code loads or keeps each flag, and the exact edge on which a word takes effect. The bench drives random and directed words against a reference model.

// File: rtl/cmdreg_pkg.sv
package cmdreg_pkg;

  localparam int CMD_W = 12;

  // Action field
  typedef enum logic [1:0] {
    ACT_PAIR0 = 2'b00,
    ACT_FEAT  = 2'b01,
    ACT_RSVD  = 2'b10,
    ACT_PAIR1 = 2'b11
  } act_e;

  // Command field
  localparam logic [2:0] CMD_DAC_WR = 3'b001;
  localparam logic [2:0] CMD_DAC_RD = 3'b011;
  localparam logic [2:0] CMD_DEV_RST = 3'b101;

  typedef struct packed {
    logic deep;
    logic nap;
    logic anap;
    logic refoff;
    logic spec;
  } feat_t;

  typedef struct packed {
    logic       accept;
    logic [1:0] chan;
    logic       set_pair;
    logic       pair_val;
    logic       load_feat;
    feat_t      feat;
    logic       dac_wr;
    logic       dac_rd;
    logic       dev_rst;
  } dec_t;

endpackage

// File: rtl/cmd_shifter.sv
module cmd_shifter #(
  parameter int WORD_W = cmdreg_pkg::CMD_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic              sdi,
  output logic [WORD_W-1:0] word_o,
  output logic              tgl_o
);
  localparam int CNT_W = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

  logic [WORD_W-2:0] sh_q;
  logic [CNT_W-1:0]  cnt_q;

  // Falling-edge capture; the finished word is handed over with a toggle.
  always_ff @(negedge clk) begin
    if (rst) begin
      sh_q   <= '0;
      cnt_q  <= '0;
      word_o <= '0;
      tgl_o  <= 1'b0;
    end else if (!rd_en) begin
      cnt_q <= '0;
    end else begin
      sh_q <= {sh_q[WORD_W-3:0], sdi};
      if (cnt_q == LAST) begin
        word_o <= {sh_q, sdi};
        tgl_o  <= ~tgl_o;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  // R3
  abort_clear_chk: assert property (@(negedge clk) disable iff (rst)
    !rd_en |=> (cnt_q == '0));

  // R2
  cnt_range_chk: assert property (@(negedge clk) disable iff (rst)
    cnt_q <= LAST);

endmodule

// File: rtl/cmd_decoder.sv
module cmd_decoder #(
  parameter int WORD_W = cmdreg_pkg::CMD_W
) (
  input  logic              auto_i,
  input  logic [WORD_W-1:0] word_i,
  output cmdreg_pkg::dec_t  dec_o
);
  import cmdreg_pkg::*;

  localparam int C_LO = WORD_W - 2;
  localparam int P_LO = WORD_W - 4;
  localparam int F_LO = WORD_W - 9;

  act_e       act;
  logic [2:0] cmd;
  logic       feat_word;

  always_comb begin
    act       = act_e'(word_i[P_LO+1:P_LO]);
    cmd       = word_i[2:0];
    feat_word = (act == ACT_FEAT);

    dec_o           = '0;
    dec_o.accept    = !auto_i && (act != ACT_RSVD);
    dec_o.chan      = word_i[C_LO+1:C_LO];
    dec_o.set_pair  = (act == ACT_PAIR0) || (act == ACT_PAIR1);
    dec_o.pair_val  = (act == ACT_PAIR1);
    dec_o.load_feat = feat_word;
    dec_o.feat      = feat_t'(word_i[F_LO+4:F_LO]);
    dec_o.dac_wr    = feat_word && (cmd == CMD_DAC_WR);
    dec_o.dac_rd    = feat_word && (cmd == CMD_DAC_RD);
    dec_o.dev_rst   = feat_word && (cmd == CMD_DEV_RST);
  end

endmodule

// File: rtl/chan_sequencer.sv
module chan_sequencer (
  input  logic clk,
  input  logic rst,
  input  logic auto_i,
  input  logic conv_done,
  input  logic clr_i,
  input  logic set_pair_i,
  input  logic pair_val_i,
  output logic pair_sel
);
  logic auto_ch_q, man_q;
  logic auto_ch_n, man_n;

  always_comb begin
    auto_ch_n = auto_ch_q;
    man_n     = man_q;
    if (clr_i) begin
      auto_ch_n = 1'b0;
      man_n     = 1'b0;
    end else begin
      if (auto_i && conv_done) auto_ch_n = ~auto_ch_q;
      if (set_pair_i)          man_n     = pair_val_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      auto_ch_q <= 1'b0;
      man_q     <= 1'b0;
      pair_sel  <= 1'b0;
    end else begin
      auto_ch_q <= auto_ch_n;
      man_q     <= man_n;
      pair_sel  <= auto_i ? auto_ch_n : man_n;
    end
  end

  // R9
  auto_flip_chk: assert property (@(posedge clk) disable iff (rst)
    (auto_i && conv_done && !clr_i) |=> (auto_ch_q != $past(auto_ch_q)));

  // R9
  manual_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!auto_i && !clr_i) |=> (auto_ch_q == $past(auto_ch_q)));

endmodule

// File: rtl/cmd_word_ctrl.sv
module cmd_word_ctrl #(
  parameter int WORD_W = cmdreg_pkg::CMD_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic              sdi,
  input  logic              m0_auto,
  input  logic              m1_single,
  input  logic              conv_done,
  output logic [WORD_W-1:0] cmd_word,
  output logic [1:0]        chan_cfg,
  output logic              pair_sel,
  output logic              deep_pd,
  output logic              nap_pd,
  output logic              auto_nap,
  output logic              ref_off,
  output logic              special_rd,
  output logic              dac_wr_stb,
  output logic              dac_rd_stb,
  output logic              dev_rst_stb,
  output logic              auto_mode,
  output logic              dual_sdo
);
  import cmdreg_pkg::*;

  logic [WORD_W-1:0] rx_word;
  logic              rx_tgl, seen_tgl;
  logic              commit;
  dec_t              dec;
  logic              do_accept, do_reset;

  cmd_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk    (clk),
    .rst    (rst),
    .rd_en  (rd_en),
    .sdi    (sdi),
    .word_o (rx_word),
    .tgl_o  (rx_tgl)
  );

  cmd_decoder #(.WORD_W(WORD_W)) u_dec (
    .auto_i (auto_mode),
    .word_i (rx_word),
    .dec_o  (dec)
  );

  assign commit    = (rx_tgl != seen_tgl);
  assign do_accept = commit && dec.accept;
  assign do_reset  = do_accept && dec.dev_rst;

  chan_sequencer u_seq (
    .clk        (clk),
    .rst        (rst),
    .auto_i     (auto_mode),
    .conv_done  (conv_done),
    .clr_i      (do_reset),
    .set_pair_i (do_accept && dec.set_pair),
    .pair_val_i (dec.pair_val),
    .pair_sel   (pair_sel)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      seen_tgl  <= 1'b0;
      auto_mode <= 1'b0;
      dual_sdo  <= 1'b0;
    end else begin
      seen_tgl  <= rx_tgl;
      auto_mode <= m0_auto;
      dual_sdo  <= ~m1_single;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dac_wr_stb  <= 1'b0;
      dac_rd_stb  <= 1'b0;
      dev_rst_stb <= 1'b0;
    end else begin
      dac_wr_stb  <= do_accept && dec.dac_wr;
      dac_rd_stb  <= do_accept && dec.dac_rd;
      dev_rst_stb <= do_reset;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || do_reset) begin
      cmd_word   <= '0;
      chan_cfg   <= '0;
      deep_pd    <= 1'b0;
      nap_pd     <= 1'b0;
      auto_nap   <= 1'b0;
      ref_off    <= 1'b0;
      special_rd <= 1'b0;
    end else if (do_accept) begin
      cmd_word <= rx_word;
      chan_cfg <= dec.chan;
      if (dec.load_feat) begin
        deep_pd    <= dec.feat.deep;
        nap_pd     <= dec.feat.nap;
        auto_nap   <= dec.feat.anap;
        ref_off    <= dec.feat.refoff;
        special_rd <= dec.feat.spec;
      end
    end
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (cmd_word == '0 && !pair_sel && !dev_rst_stb && !deep_pd));

  // R7
  strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({dac_wr_stb, dac_rd_stb, dev_rst_stb}));

  // R7
  wr_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    dac_wr_stb |=> !dac_wr_stb);

  // R7
  rd_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    dac_rd_stb |=> !dac_rd_stb);

  // R8
  dev_reset_chk: assert property (@(posedge clk) disable iff (rst)
    dev_rst_stb |-> (cmd_word == '0 && !pair_sel && chan_cfg == '0));

  // R9
  auto_freeze_chk: assert property (@(posedge clk) disable iff (rst)
    auto_mode |=> $stable(cmd_word));

  // R10
  width_flag_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (dual_sdo == !$past(m1_single)));

endmodule

// File: tb/test_cmd_word_ctrl.sv
module test_cmd_word_ctrl;
  logic clk = 1'b0, rst = 1'b1, rd_en = 1'b0, sdi = 1'b0;
  logic m0_auto = 1'b0, m1_single = 1'b0, conv_done = 1'b0;
  logic [11:0] cmd_word;
  logic [1:0]  chan_cfg;
  logic pair_sel, deep_pd, nap_pd, auto_nap, ref_off, special_rd;
  logic dac_wr_stb, dac_rd_stb, dev_rst_stb, auto_mode, dual_sdo;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  // expected model
  logic [11:0] e_word;
  logic [1:0]  e_chan;
  logic [4:0]  e_feat;
  logic        e_man, e_ach, e_auto;

  always #10 clk = ~clk;

  cmd_word_ctrl i_cmd_word_ctrl (
    .clk(clk), .rst(rst), .rd_en(rd_en), .sdi(sdi), .m0_auto(m0_auto),
    .m1_single(m1_single), .conv_done(conv_done), .cmd_word(cmd_word),
    .chan_cfg(chan_cfg), .pair_sel(pair_sel), .deep_pd(deep_pd),
    .nap_pd(nap_pd), .auto_nap(auto_nap), .ref_off(ref_off),
    .special_rd(special_rd), .dac_wr_stb(dac_wr_stb), .dac_rd_stb(dac_rd_stb),
    .dev_rst_stb(dev_rst_stb), .auto_mode(auto_mode), .dual_sdo(dual_sdo)
  );

  task automatic check(input string req, input logic [11:0] act, input logic [11:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [2:0] exp_strobes(input logic [11:0] w, input logic auto);
    logic [2:0] s = 3'b000;
    if (!auto && w[9:8] == 2'b01) begin
      if (w[2:0] == 3'b001) s[2] = 1'b1;
      if (w[2:0] == 3'b011) s[1] = 1'b1;
      if (w[2:0] == 3'b101) s[0] = 1'b1;
    end
    return s;
  endfunction

  task automatic model_clear();
    e_word = '0; e_chan = '0; e_feat = '0; e_man = 1'b0; e_ach = 1'b0;
  endtask

  task automatic model_word(input logic [11:0] w);
    if (e_auto || w[9:8] == 2'b10) return;
    if (w[9:8] == 2'b01 && w[2:0] == 3'b101) begin model_clear(); return; end
    e_word = w;
    e_chan = w[11:10];
    if (w[9:8] == 2'b00) e_man = 1'b0;
    if (w[9:8] == 2'b11) e_man = 1'b1;
    if (w[9:8] == 2'b01) e_feat = w[7:3];
  endtask

  task automatic check_state(input string req);
    check({req, " word"}, cmd_word, e_word);
    check({req, " chan"}, {10'd0, chan_cfg}, {10'd0, e_chan});
    check({req, " flags"}, {7'd0, deep_pd, nap_pd, auto_nap, ref_off, special_rd},
          {7'd0, e_feat});
    check({req, " pair"}, {11'd0, pair_sel}, {11'd0, e_auto ? e_ach : e_man});
  endtask

  // Sends nbits of w MSB first; returns 2 ns after the commit edge.
  task automatic send(input logic [11:0] w, input int nbits);
    for (int i = 0; i < nbits; i++) begin
      @(posedge clk); #2;
      rd_en = 1'b1;
      sdi   = w[11-i];
    end
    @(posedge clk); #2;
    rd_en = 1'b0;
    sdi   = 1'b0;
  endtask

  task automatic send_full(input logic [11:0] w, input string req);
    logic [2:0] s;
    s = exp_strobes(w, e_auto);
    send(w, 12);
    model_word(w);
    check({req, " R7 strobes"}, {9'd0, dac_wr_stb, dac_rd_stb, dev_rst_stb}, {9'd0, s});
    check_state(req);
    @(posedge clk); #2;
    check({req, " R7 strobe width"}, {9'd0, dac_wr_stb, dac_rd_stb, dev_rst_stb}, 12'd0);
  endtask

  task automatic pulse_conv(input string req);
    @(posedge clk); #2; conv_done = 1'b1;
    @(posedge clk); #2; conv_done = 1'b0;
    if (e_auto) e_ach = ~e_ach;
    check_state(req);
  endtask

  task automatic set_modes(input logic a, input logic s);
    @(posedge clk); #2; m0_auto = a; m1_single = s;
    e_auto = a;
    repeat (3) @(posedge clk);
    #2;
    check("R10 auto_mode", {11'd0, auto_mode}, {11'd0, a});
    check("R10 dual_sdo", {11'd0, dual_sdo}, {11'd0, ~s});
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [11:0] w;
    int sel;
    void'($urandom(32'd20240611));
    e_auto = 1'b0;
    model_clear();
    repeat (4) @(posedge clk);
    #2; rst = 1'b0;
    @(posedge clk); #2;
    // R1 reset state
    check_state("R1");
    check("R1 strobes", {9'd0, dac_wr_stb, dac_rd_stb, dev_rst_stb}, 12'd0);

    // R2 / R4 directed: MSB-first placement, pair 1
    send_full(12'b10_11_00000_000, "R2 R4 pair1");
    send_full(12'b01_00_00000_110, "R4 pair0");
    // R5 feature load, then keep on pair word
    send_full(12'b00_01_10101_000, "R5 load");
    send_full(12'b11_11_01010_000, "R5 keep");
    // R6 reserved word ignored
    send_full(12'b00_10_11111_101, "R6 reserved");
    // R7 strobes
    send_full(12'b00_01_00000_001, "R7 dac write");
    send_full(12'b00_01_00000_011, "R7 dac read");
    send_full(12'b00_11_00000_001, "R7 no strobe outside P=01");
    // R3 truncated word discarded, then a full word still aligns
    send(12'hFFF, 7);
    check_state("R3 partial");
    send(12'hFFF, 11);
    check_state("R3 eleven bits");
    send_full(12'b01_00_11000_000, "R3 realign");
    // R8 device reset
    send_full(12'b11_11_00000_000, "R8 setup");
    send_full(12'b11_01_11111_101, "R8 reset");
    // R9 automatic mode
    set_modes(1'b1, 1'b1);
    check_state("R9 entry");
    pulse_conv("R9 flip1");
    pulse_conv("R9 flip2");
    pulse_conv("R9 flip3");
    send_full(12'b10_11_11111_001, "R9 word ignored");
    set_modes(1'b0, 1'b0);
    pulse_conv("R9 manual no effect");
    send_full(12'b00_01_00000_101, "R8 reset clears pointer");

    // random mix
    for (int n = 0; n < 150; n++) begin
      sel = $urandom_range(0, 9);
      w = 12'($urandom());
      if (sel < 5) send_full(w, "R2 R5 random word");
      else if (sel == 5) begin send(w, $urandom_range(1, 11)); check_state("R3 random partial"); end
      else if (sel == 6) pulse_conv("R9 random conv");
      else if (sel == 7) set_modes(1'($urandom()), 1'($urandom()));
      else send_full({w[11:10], 2'b01, w[7:3], 3'b101}, "R8 random reset");
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule